// File: doc/BRIEF.md
# Peripheral Enable and Address Router

This block holds the configuration word that switches on the on-chip bus peripherals one at a time. It also routes every CPU access that falls into two address regions. The first region is a fixed 2 KB peripheral window. An access there goes to the on-chip peripheral bus while at least one non-memory peripheral is enabled. When none is enabled, the access goes to the external memory interface instead.

The second region is one 64 KB memory segment. Its target depends on three things: a boot pin sampled during reset, a sticky global enable, and the two large-memory enables in the configuration word. For that segment the target can be internal flash, external memory, or a reserved slot that raises an error.

Software sets the global enable once. From then on the configuration word is frozen. An emulation input forces every enable on. A write-only shadow register holds a copy of the configuration for emulation hardware and presents it on a dedicated output. All routing selects are combinational, so they are valid in the same cycle as the request.

Top module: `periph_route`

## Requirements
- R1: After reset the enable vector is 0x101 (bit 0 and bit 8 set), the global enable is 0 and the shadow output is 0.
- R2: A write to CFG_ADDR while unlocked stores data bits 10:0. The bit map is: 0 first CAN, 1 second CAN, 2 real-time clock, 3 extra UART, 4 extra synchronous serial, 5 I2C, 6 PWM, 7 extra bus features, 8 2 KB RAM, 9 64 KB RAM, 10 flash. A read of CFG_ADDR returns the effective enables on bits 10:0, with bits 15:11 always 0.
- R3: A one-cycle pulse on sysEnSet sets globalEn from the next cycle until reset. While globalEn is 1, writes to CFG_ADDR leave the enables unchanged.
- R4: While emuMode is 1, periphEn and the CFG_ADDR readback show all 11 enables set. The stored value is not altered and reappears when emuMode returns to 0.
- R5: A write to 0x00EB7E stores all 16 data bits, whether or not the block is locked. The stored value appears on shadowOut from the next cycle, and a read of that address returns 0.
- R6: A valid access to 0x00E800..0x00EFFF asserts selOnchip in the same cycle if any effective enable among bits 7:0 is set, otherwise selExt.
- R7: A valid access with address bits 23:16 equal to 0x08 asserts selFlash when the sampled boot pin is 1.
- R8: With a sampled boot pin of 0, a segment 0x08 access asserts selExt when globalEn is 0, or when effective bits 9 and 10 are both 0. Otherwise it asserts segErr and no select.
- R9: The boot pin is sampled while reset is asserted. Changes to it after reset is released have no effect on routing.
- R10: At most one of selOnchip, selExt, selFlash and segErr is high. None is high for an access outside both regions or when accValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| bootPin | input | 1 | Segment target pin, sampled during reset |
| emuMode | input | 1 | Forces all enables on |
| sysEnSet | input | 1 | Pulse that sets the sticky global enable |
| accValid | input | 1 | Access request |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | 24 | Access address |
| accWdata | input | 16 | Write data |
| accRdata | output | 16 | Read data, same cycle |
| periphEn | output | 11 | Effective per-peripheral enables |
| globalEn | output | 1 | Sticky global enable |
| shadowOut | output | 16 | Shadow register contents |
| selOnchip | output | 1 | Route to on-chip peripheral bus |
| selExt | output | 1 | Route to external memory |
| selFlash | output | 1 | Route to internal flash |
| segErr | output | 1 | Reserved segment access strobe |

## Verification
A corrupted enable word shows up in two places at once. It appears on periphEn in the cycle after the write, and it turns window accesses toward the wrong bus the moment a request arrives. For that reason, every cycle of stimulus compares the enables, the readback and all four selects against a reference model. A lock flop that drops, or a boot latch that follows the pin after reset, shows up on the first later write or segment access, as a changed enable or a wrong segment target. The random mix deliberately clears the low byte of written data often, so that the external fallback of the window is exercised.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int EN_BITS = 11;
  localparam int NONMEM_BITS = 8;
  localparam int RAM64_BIT = 9;
  localparam int FLASH_BIT = 10;

  typedef struct packed {
    logic cfgWr;
    logic shadowWr;
    logic cfgRd;
    logic inWindow;
    logic inSeg;
  } strobe_t;
endpackage

// File: rtl/prt_ctrl.sv
module prt_ctrl
  import prt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 24'h00F1C0,
  parameter logic [ADDR_W-1:0] SHADOW_ADDR = 24'h00EB7E,
  parameter logic [ADDR_W-1:0] WIN_LO = 24'h00E800,
  parameter logic [ADDR_W-1:0] WIN_HI = 24'h00EFFF,
  parameter logic [ADDR_W-17:0] SEG_ID = 8'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              sysEnSet,
  output strobe_t           stb,
  output logic              globalEn
);
  logic hitCfg, hitShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) globalEn <= 1'b0;
    else if (sysEnSet) globalEn <= 1'b1;
  end

  assign hitCfg    = (accAddr == CFG_ADDR);
  assign hitShadow = (accAddr == SHADOW_ADDR);

  always_comb begin
    stb.cfgWr    = accValid & accWrite & hitCfg & ~globalEn;
    stb.shadowWr = accValid & accWrite & hitShadow;
    stb.cfgRd    = accValid & ~accWrite & hitCfg;
    stb.inWindow = accValid & (accAddr >= WIN_LO) & (accAddr <= WIN_HI);
    stb.inSeg    = accValid & (accAddr[ADDR_W-1:16] == SEG_ID);
  end

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    globalEn |=> globalEn);
endmodule

// File: rtl/prt_dpath.sv
module prt_dpath
  import prt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [EN_BITS-1:0] RST_EN = 11'h101
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               globalEn,
  input  logic               emuMode,
  input  logic               bootPin,
  input  logic [DATA_W-1:0]  accWdata,
  output logic [DATA_W-1:0]  accRdata,
  output logic [EN_BITS-1:0] periphEn,
  output logic [DATA_W-1:0]  shadowOut,
  output logic               selOnchip,
  output logic               selExt,
  output logic               selFlash,
  output logic               segErr
);
  logic [EN_BITS-1:0] cfgQ;
  logic bootQ, anyPeriph, memOn, segLocal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= RST_EN;
      shadowOut <= '0;
    end else begin
      if (stb.cfgWr)    cfgQ      <= accWdata[EN_BITS-1:0];
      if (stb.shadowWr) shadowOut <= accWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) bootQ <= bootPin;
  end

  assign periphEn  = emuMode ? {EN_BITS{1'b1}} : cfgQ;
  assign anyPeriph = |periphEn[NONMEM_BITS-1:0];
  assign memOn     = periphEn[RAM64_BIT] | periphEn[FLASH_BIT];
  assign segLocal  = stb.inSeg & ~bootQ;

  assign selOnchip = stb.inWindow & anyPeriph;
  assign selExt    = (stb.inWindow & ~anyPeriph) | (segLocal & ~(globalEn & memOn));
  assign selFlash  = stb.inSeg & bootQ;
  assign segErr    = segLocal & globalEn & memOn;
  assign accRdata  = stb.cfgRd ? {{(DATA_W-EN_BITS){1'b0}}, periphEn} : '0;

  // R3
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    globalEn |=> $stable(cfgQ));
  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selOnchip, selExt, selFlash, segErr}));
  // R4
  emu_all_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    emuMode |-> (&periphEn));
  // R9
  boot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(bootQ));
endmodule

// File: rtl/periph_route.sv
module periph_route
  import prt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 24'h00F1C0,
  parameter logic [ADDR_W-1:0] SHADOW_ADDR = 24'h00EB7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootPin,
  input  logic              emuMode,
  input  logic              sysEnSet,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWdata,
  output logic [DATA_W-1:0] accRdata,
  output logic [10:0]       periphEn,
  output logic              globalEn,
  output logic [DATA_W-1:0] shadowOut,
  output logic              selOnchip,
  output logic              selExt,
  output logic              selFlash,
  output logic              segErr
);
  strobe_t stb;

  prt_ctrl #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .SHADOW_ADDR(SHADOW_ADDR)) ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .sysEnSet(sysEnSet), .stb(stb), .globalEn(globalEn));

  prt_dpath #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .globalEn(globalEn), .emuMode(emuMode),
    .bootPin(bootPin), .accWdata(accWdata), .accRdata(accRdata),
    .periphEn(periphEn), .shadowOut(shadowOut), .selOnchip(selOnchip),
    .selExt(selExt), .selFlash(selFlash), .segErr(segErr));
endmodule

// File: tb/periph_route_test.sv
`timescale 1ns/1ps
module periph_route_test;
  localparam logic [23:0] CFG = 24'h00F1C0;
  localparam logic [23:0] SHD = 24'h00EB7E;

  logic clk = 1'b0, rstN = 1'b0, bootPin = 1'b0, emuMode = 1'b0, sysEnSet = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0;
  logic [23:0] accAddr = '0;
  logic [15:0] accWdata = '0;
  logic [15:0] accRdata, shadowOut;
  logic [10:0] periphEn;
  logic globalEn, selOnchip, selExt, selFlash, segErr;

  int total = 0, bad = 0;
  logic [10:0] mCfg;
  logic [15:0] mShd;
  logic mGen, mBoot;

  always #2 clk = ~clk;

  periph_route uut (.*);

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] effF(logic [10:0] c, logic e);
    return e ? 11'h7FF : c;
  endfunction

  // returns {onchip, ext, flash, err}
  function automatic logic [3:0] routeF(logic v, logic [23:0] a, logic [10:0] en, logic g, logic b);
    if (!v) return 4'b0000;
    if (a >= 24'h00E800 && a <= 24'h00EFFF) return (|en[7:0]) ? 4'b1000 : 4'b0100;
    if (a[23:16] == 8'h08) begin
      if (b) return 4'b0010;
      if (!g || !(en[9] | en[10])) return 4'b0100;
      return 4'b0001;
    end
    return 4'b0000;
  endfunction

  task automatic doOp(logic v, logic w, logic [23:0] a, logic [15:0] d, logic e, logic s);
    logic [10:0] en;
    string rr, er;
    accValid = v; accWrite = w; accAddr = a; accWdata = d; emuMode = e; sysEnSet = s;
    #1;
    en = effF(mCfg, e);
    if (a >= 24'h00E800 && a <= 24'h00EFFF) rr = "R6";
    else if (a[23:16] == 8'h08) rr = mBoot ? "R7" : "R8/R9";
    else rr = "R10";
    check(rr, {selOnchip, selExt, selFlash, segErr}, routeF(v, a, en, mGen, mBoot));
    er = e ? "R4" : (mGen ? "R3" : "R2");
    check(er, periphEn, en);
    if (v && !w && a == CFG) check(er, accRdata, {5'b0, en});
    if (v && !w && a == SHD) check("R5", accRdata, 0);
    check("R5", shadowOut, mShd);
    check("R3", globalEn, mGen);
    if (v && w && a == CFG && !mGen) mCfg = d[10:0];
    if (v && w && a == SHD) mShd = d;
    if (s) mGen = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(logic b);
    @(negedge clk);
    rstN = 1'b0; bootPin = b; accValid = 1'b0; emuMode = 1'b0; sysEnSet = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mCfg = 11'h101; mShd = '0; mGen = 1'b0; mBoot = b;
    #1;
    check("R1", periphEn, 11'h101);
    check("R1", globalEn, 0);
    check("R1", shadowOut, 0);
    bootPin = ~b; // R9: later pin changes must not matter
  endtask

  task automatic randOp(bit allowSet);
    logic [23:0] a;
    logic [15:0] d;
    int k;
    k = $urandom % 7;
    case (k)
      0: a = CFG;
      1: a = SHD;
      2: a = 24'h00E800 + ($urandom % 24'h800);
      3: a = ($urandom % 2) ? (($urandom % 2) ? 24'h00E7FF : 24'h00F000)
                            : (($urandom % 2) ? 24'h00E800 : 24'h00EFFF);
      4: a = {8'h08, 16'($urandom)};
      5: a = {8'h12, 16'($urandom)};
      default: a = 24'h00E800 + ($urandom % 24'h800);
    endcase
    d = 16'($urandom);
    if ($urandom % 3 == 0) d[7:0] = 8'h00;
    if ($urandom % 2 == 0) d[10:9] = 2'b00;
    if (($urandom % 4) == 0) bootPin = ~bootPin;
    doOp(($urandom % 8) != 0, ($urandom % 2) == 1, a, d, ($urandom % 8) == 0,
         allowSet && (($urandom % 50) == 0));
  endtask

  initial begin
    void'($urandom(32'd1357));
    doReset(1'b0);
    for (int i = 0; i < 400; i++) randOp(1'b0);
    // directed: lock with 64 KB RAM enabled -> reserved segment (R8)
    doOp(1, 1, CFG, 16'hFA00, 0, 0);
    doOp(1, 0, CFG, 0, 0, 0);            // R2 reserved bits read 0
    doOp(0, 0, 0, 0, 0, 1);              // R3 lock
    doOp(1, 0, 24'h081234, 0, 0, 0);     // R8 segErr
    doOp(1, 1, CFG, 16'h00FF, 0, 0);     // R3 ignored
    doOp(1, 0, CFG, 0, 0, 0);
    doOp(1, 0, 24'h00E900, 0, 0, 0);     // R6 external, no periph
    doOp(1, 0, CFG, 0, 1, 0);            // R4 emu readback
    doOp(1, 0, 24'h00E900, 0, 1, 0);     // R4/R6 onchip under emu
    doOp(1, 0, CFG, 0, 0, 0);            // R4 stored value back
    doOp(1, 1, SHD, 16'hBEEF, 0, 0);     // R5 after lock
    doOp(1, 0, SHD, 0, 0, 0);
    for (int i = 0; i < 300; i++) randOp(1'b1);
    doReset(1'b1);
    for (int i = 0; i < 200; i++) randOp(1'b1);
    doReset(1'b0);
    doOp(0, 0, 0, 0, 0, 1);
    doOp(1, 0, 24'h080000, 0, 0, 0);     // R8 locked, mem enables off -> ext
    doOp(1, 1, CFG, 16'h0400, 0, 0);     // ignored
    doOp(1, 0, 24'h08FFFF, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule